// File: doc/BRIEF.md
# Rejected Interrupt Replay Bitmap

This block keeps a record of interrupts that the downstream presenter has refused, so that they can be delivered again later. Each refusal arrives as a global interrupt number. The block subtracts a programmable source base, checks that the result lies inside its 2048-source window, and sets one bit in a bitmap of 32 words of 64 bits. A 32-bit summary register marks which words hold at least one recorded bit.

When a resend request arrives, a scan starts. It walks the summary upward from word 0 and skips every word whose summary bit is clear. For each word it visits, it clears the summary bit first and then walks the word's bits upward. Every recorded bit is cleared and offered to the dispatcher as a forced replay event, which bypasses any stored pending or queued state. Events are offered one per valid/ready handshake. A refusal that arrives during a scan is merged into the stored state and is never lost. It is replayed in the same scan if the scan has not yet passed its position; otherwise it waits for the next resend.

The controller has four states. `ST_IDLE` waits for a resend. `ST_SEEK_WORD` finds the next non-empty word at or above the word pointer. `ST_SEEK_BIT` finds the next set bit at or above the bit pointer. `ST_OFFER` holds an event until it is accepted. The transitions are:
- idle to seek-word, on a resend with a non-zero summary;
- seek-word to seek-bit, when a word is found;
- seek-word to idle, when no word is left;
- seek-bit to offer, when a bit is found;
- seek-bit to seek-word, when the word is exhausted; this advances the word pointer;
- offer to seek-bit, on acceptance.

Top module: `rrb_resend_bitmap`

## Requirements
- R1: After reset, `busy`, `replay_valid` and `rej_bad` are low, and both the bitmap and the summary are empty.
- R2: A valid refusal with number N is recorded at local index L = N - `src_base`. The word is L>>6 and the bit is L&63. Summary bit [L>>6] is set as well, and the source is later replayed as `replay_src` = L.
- R3: A resend while the summary is all zero starts no scan: `busy` stays low and no event is offered.
- R4: A scan offers recorded sources in ascending local index order and skips words whose summary bit is clear.
- R5: Each recorded source is replayed exactly once and then cleared, so a second resend replays nothing more.
- R6: While `replay_valid` is high and `replay_ready` is low, `replay_valid` and `replay_src` hold their values. Each accepted handshake removes one event.
- R7: A refusal that arrives during a scan above the last offered index is replayed in the same scan. One at or below that index is kept for the next resend.
- R8: A refusal whose number is below `src_base`, or whose local index is 2048 or more, is ignored. `rej_bad` is high in the cycle after it and low after an in-range refusal or no refusal.
- R9: `busy` rises on the edge that samples a resend with a non-empty summary. It is high whenever an event is offered, and falls once no recorded bit remains above the scan position.
- R10: Several refusals of the same source before a resend give a single replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_base | input | 24 | Global number of local source 0 |
| rej_valid | input | 1 | Refusal present this cycle |
| rej_num | input | 24 | Global number of the refused interrupt |
| resend_req | input | 1 | Start a replay scan |
| replay_ready | input | 1 | Dispatcher accepts the offered event |
| rej_bad | output | 1 | Previous-cycle refusal was out of window |
| busy | output | 1 | A scan is in progress |
| replay_valid | output | 1 | A forced replay event is offered |
| replay_src | output | 11 | Local source index of the offered event |

## Verification
`rej_bad` and the rise of `busy` are each due one clock edge after the input that causes them. A replay event appears some cycles after the resend, because the controller passes through its seek states first, and it then holds until the edge where ready is sampled high. The bench drives its inputs and samples the outputs on the falling edge, so every check reads the state left by the preceding rising edge. The reference model keeps a plain per-source array and a scan position. Each newly offered event is compared with the lowest recorded index at or above that position, and the held value is compared on every later cycle until acceptance. Mid-scan refusals are injected only while an event is being held, so the model and the design always see them at the same point of the scan.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEEK_WORD,
        ST_SEEK_BIT,
        ST_OFFER
    } scan_state_t;
endpackage

// File: rtl/rrb_ffs.sv
module rrb_ffs #(
    parameter int W = 64,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    input  logic [IW:0]   from,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // lowest set position at or above 'from'
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i] && ((IW + 1)'(i) >= from)) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rrb_index.sv
module rrb_index #(
    parameter int IRQ_W = 24,
    parameter int SRC_W = 11
) (
    input  logic [IRQ_W-1:0] num,
    input  logic [IRQ_W-1:0] base,
    output logic             ok,
    output logic [SRC_W-1:0] loc_idx
);
    logic [IRQ_W-1:0] diff;

    assign diff    = num - base;
    assign ok      = (num >= base) && (diff[IRQ_W-1:SRC_W] == '0);
    assign loc_idx = diff[SRC_W-1:0];
endmodule

// File: rtl/rrb_scan_ctl.sv
module rrb_scan_ctl
    import rrb_pkg::*;
#(
    parameter int NUM_WORDS = 32,
    parameter int WORD_BITS = 64,
    localparam int WW = $clog2(NUM_WORDS),
    localparam int BW = $clog2(WORD_BITS),
    localparam int SRC_W = WW + BW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 resend_req,
    input  logic [NUM_WORDS-1:0] summary,
    input  logic [WORD_BITS-1:0] word_bits,
    input  logic                 replay_ready,
    output logic                 busy,
    output logic                 replay_valid,
    output logic [SRC_W-1:0]     replay_src,
    output logic [WW-1:0]        cur_word_o,
    output logic                 sum_clr_en,
    output logic [WW-1:0]        sum_clr_idx,
    output logic                 bit_clr_en,
    output logic [BW-1:0]        bit_clr_idx
);
    scan_state_t      st, st_nx;
    logic [WW:0]      cur_word, word_nx;
    logic [BW:0]      cur_bit, bit_nx;
    logic [SRC_W-1:0] out_src, src_nx;
    logic             w_hit, b_hit;
    logic [WW-1:0]    w_idx;
    logic [BW-1:0]    b_idx;

    rrb_ffs #(.W(NUM_WORDS)) word_find_i (
        .vec(summary), .from(cur_word), .hit(w_hit), .idx(w_idx)
    );
    rrb_ffs #(.W(WORD_BITS)) bit_find_i (
        .vec(word_bits), .from(cur_bit), .hit(b_hit), .idx(b_idx)
    );

    always_comb begin
        st_nx   = st;
        word_nx = cur_word;
        bit_nx  = cur_bit;
        src_nx  = out_src;
        unique case (st)
            ST_IDLE: begin
                if (resend_req && (|summary)) begin
                    st_nx   = ST_SEEK_WORD;
                    word_nx = '0;
                end
            end
            ST_SEEK_WORD: begin
                if (w_hit) begin
                    st_nx   = ST_SEEK_BIT;
                    word_nx = {1'b0, w_idx};
                    bit_nx  = '0;
                end else begin
                    st_nx = ST_IDLE;
                end
            end
            ST_SEEK_BIT: begin
                if (b_hit) begin
                    st_nx  = ST_OFFER;
                    src_nx = {cur_word[WW-1:0], b_idx};
                    bit_nx = {1'b0, b_idx} + (BW + 1)'(1);
                end else begin
                    st_nx   = ST_SEEK_WORD;
                    word_nx = cur_word + (WW + 1)'(1);
                end
            end
            ST_OFFER: begin
                if (replay_ready) st_nx = ST_SEEK_BIT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cur_word <= '0;
            cur_bit  <= '0;
            out_src  <= '0;
        end else begin
            st       <= st_nx;
            cur_word <= word_nx;
            cur_bit  <= bit_nx;
            out_src  <= src_nx;
        end
    end

    always_comb begin
        busy         = (st != ST_IDLE);
        replay_valid = (st == ST_OFFER);
        replay_src   = out_src;
        cur_word_o   = cur_word[WW-1:0];
        sum_clr_en   = (st == ST_SEEK_WORD) && w_hit;
        sum_clr_idx  = w_idx;
        bit_clr_en   = (st == ST_SEEK_BIT) && b_hit;
        bit_clr_idx  = b_idx;
    end

    // R3
    empty_resend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && resend_req && summary == '0) |=> (st == ST_IDLE));

    // R9
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && resend_req && summary != '0) |=> busy);

    // R6
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (replay_valid && !replay_ready) |=> (replay_valid && $stable(replay_src)));
endmodule

// File: rtl/rrb_resend_bitmap.sv
module rrb_resend_bitmap #(
    parameter int NUM_WORDS = 32,
    parameter int WORD_BITS = 64,
    parameter int IRQ_W     = 24,
    localparam int WW    = $clog2(NUM_WORDS),
    localparam int BW    = $clog2(WORD_BITS),
    localparam int SRC_W = WW + BW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] src_base,
    input  logic             rej_valid,
    input  logic [IRQ_W-1:0] rej_num,
    input  logic             resend_req,
    input  logic             replay_ready,
    output logic             rej_bad,
    output logic             busy,
    output logic             replay_valid,
    output logic [SRC_W-1:0] replay_src
);
    logic [WORD_BITS-1:0] bitmap    [NUM_WORDS];
    logic [WORD_BITS-1:0] bitmap_nx [NUM_WORDS];
    logic [NUM_WORDS-1:0] summary, summary_nx;

    logic             dec_ok;
    logic [SRC_W-1:0] loc_idx;
    logic             rec_en;
    logic [WW-1:0]    rec_word;
    logic [BW-1:0]    rec_bit;
    logic [WW-1:0]    cur_word;
    logic             sum_clr_en, bit_clr_en;
    logic [WW-1:0]    sum_clr_idx;
    logic [BW-1:0]    bit_clr_idx;

    rrb_index #(.IRQ_W(IRQ_W), .SRC_W(SRC_W)) index_i (
        .num(rej_num), .base(src_base), .ok(dec_ok), .loc_idx(loc_idx)
    );

    assign rec_en   = rej_valid && dec_ok;
    assign rec_word = loc_idx[SRC_W-1:BW];
    assign rec_bit  = loc_idx[BW-1:0];

    rrb_scan_ctl #(.NUM_WORDS(NUM_WORDS), .WORD_BITS(WORD_BITS)) ctl_i (
        .clk(clk), .rst_n(rst_n), .resend_req(resend_req),
        .summary(summary), .word_bits(bitmap[cur_word]),
        .replay_ready(replay_ready), .busy(busy),
        .replay_valid(replay_valid), .replay_src(replay_src),
        .cur_word_o(cur_word), .sum_clr_en(sum_clr_en),
        .sum_clr_idx(sum_clr_idx), .bit_clr_en(bit_clr_en),
        .bit_clr_idx(bit_clr_idx)
    );

    // a new refusal wins over a same-cycle clear, so nothing is lost
    always_comb begin
        summary_nx = summary;
        if (sum_clr_en) summary_nx[sum_clr_idx] = 1'b0;
        if (rec_en)     summary_nx[rec_word]    = 1'b1;
        for (int w = 0; w < NUM_WORDS; w++) begin
            bitmap_nx[w] = bitmap[w];
            if (bit_clr_en && cur_word == WW'(w)) bitmap_nx[w][bit_clr_idx] = 1'b0;
            if (rec_en && rec_word == WW'(w))     bitmap_nx[w][rec_bit]     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            summary <= '0;
            rej_bad <= 1'b0;
            for (int w = 0; w < NUM_WORDS; w++) bitmap[w] <= '0;
        end else begin
            summary <= summary_nx;
            rej_bad <= rej_valid && !dec_ok;
            for (int w = 0; w < NUM_WORDS; w++) bitmap[w] <= bitmap_nx[w];
        end
    end

    // R2
    record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rej_valid && dec_ok) |=> (summary[$past(rec_word)] && bitmap[$past(rec_word)][$past(rec_bit)]));

    // R8
    bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rej_valid && !dec_ok) |=> rej_bad);

    // R8
    good_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rej_valid || dec_ok) |=> !rej_bad);

    // R9
    offer_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        replay_valid |-> busy);
endmodule

// File: tb/rrb_resend_bitmap_tb.sv
module rrb_resend_bitmap_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] src_base = '0;
    logic        rej_valid = 1'b0;
    logic [23:0] rej_num = '0;
    logic        resend_req = 1'b0;
    logic        replay_ready = 1'b0;
    logic        rej_bad, busy, replay_valid;
    logic [10:0] replay_src;

    int n_run = 0;
    int n_fail = 0;
    bit rec [0:2047];
    int ptr = 0;

    always #4 clk = ~clk;

    rrb_resend_bitmap dut_i (
        .clk(clk), .rst_n(rst_n), .src_base(src_base),
        .rej_valid(rej_valid), .rej_num(rej_num),
        .resend_req(resend_req), .replay_ready(replay_ready),
        .rej_bad(rej_bad), .busy(busy),
        .replay_valid(replay_valid), .replay_src(replay_src)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int next_rec(input int from);
        for (int i = from; i < 2048; i++) if (rec[i]) return i;
        return -1;
    endfunction

    // drive one refusal (global number) and check the flag one edge later
    task automatic reject(input int gnum, input bit expect_bad);
        rej_valid = 1'b1;
        rej_num   = 24'(gnum);
        if (!expect_bad) rec[gnum - int'(src_base)] = 1'b1;
        @(negedge clk);
        rej_valid = 1'b0;
        chk(rej_bad == expect_bad, "R8 rej_bad", int'(rej_bad), int'(expect_bad));
    endtask

    // mode 0: ready at once, 1: ready after two held cycles,
    // 2: hold source 200 for three cycles and inject refusals meanwhile
    task automatic run_scan(input int mode, input int exp_n);
        int n = 0;
        int hold = 0;
        int cyc = 0;
        bit seen = 1'b0;
        int held = 0;
        resend_req = 1'b1;
        ptr = 0;
        @(negedge clk);
        resend_req = 1'b0;
        if (exp_n > 0) chk(busy == 1'b1, "R9 busy rise", int'(busy), 1);
        while (busy && cyc < 20000) begin
            rej_valid = 1'b0;
            replay_ready = 1'b0;
            if (replay_valid) begin
                if (!seen) begin
                    chk(int'(replay_src) == next_rec(ptr), "R4 replay order", int'(replay_src), next_rec(ptr));
                    held = int'(replay_src);
                    rec[held] = 1'b0;
                    ptr = held + 1;
                    seen = 1'b1;
                    hold = 0;
                    n++;
                end else begin
                    chk(int'(replay_src) == held, "R6 held source", int'(replay_src), held);
                end
                if (mode == 2 && held == 200 && hold < 3) begin
                    rej_valid = 1'b1;
                    case (hold)
                        0: rej_num = src_base + 24'd150;
                        1: rej_num = src_base + 24'd900;
                        default: rej_num = src_base + 24'd200;
                    endcase
                    rec[int'(rej_num - src_base)] = 1'b1;
                end
                replay_ready = (mode == 0) || (mode == 1 && hold >= 2) ||
                               (mode == 2 && (held != 200 || hold >= 3));
                if (replay_ready) seen = 1'b0;
                hold++;
            end
            @(negedge clk);
            cyc++;
            chk(!replay_valid || busy, "R9 busy with offer", int'(busy), 1);
        end
        rej_valid = 1'b0;
        replay_ready = 1'b0;
        chk(!busy, "R9 busy falls", int'(busy), 0);
        chk(n == exp_n, "R5 replay count", n, exp_n);
        chk(next_rec(ptr) == -1, "R7 nothing left above scan", next_rec(ptr), -1);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2048; i++) rec[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy, "R1 busy", int'(busy), 0);
        chk(!replay_valid, "R1 replay_valid", int'(replay_valid), 0);
        chk(!rej_bad, "R1 rej_bad", int'(rej_bad), 0);

        // R3: empty summary, no scan
        resend_req = 1'b1;
        @(negedge clk);
        resend_req = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(!busy && !replay_valid, "R3 empty resend idle", int'(busy), 0);
            @(negedge clk);
        end

        // R2, R8, R10: mapping, out-of-window and duplicates
        src_base = 24'h100;
        reject(32'h100 + 5, 1'b0);
        reject(32'h100 + 70, 1'b0);
        reject(32'h0FF, 1'b1);
        reject(32'h100 + 2047, 1'b0);
        reject(32'h100 + 2048, 1'b1);
        reject(32'h100 + 0, 1'b0);
        reject(32'h100 + 64, 1'b0);
        reject(32'h100 + 5, 1'b0);
        @(negedge clk);
        chk(!rej_bad, "R8 flag clears", int'(rej_bad), 0);
        run_scan(0, 5);

        // R5: nothing left for a second resend
        run_scan(0, 0);

        // R6: back-pressure with a different base
        src_base = 24'h4000;
        reject(32'h4000 + 63, 1'b0);
        reject(32'h4000 + 1500, 1'b0);
        reject(32'h4000 + 64, 1'b0);
        run_scan(1, 3);

        // R7: refusals during a scan
        reject(32'h4000 + 10, 1'b0);
        reject(32'h4000 + 200, 1'b0);
        reject(32'h4000 + 1000, 1'b0);
        run_scan(2, 4);
        run_scan(0, 2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule